// File: doc/BRIEF.md
# On-Off Backpressure Link with Hysteresis

This block models both ends of a point-to-point flit link that uses a single level wire for backpressure instead of per-flit credits. The receiving end counts its free flit slots. When free space falls under a low threshold it drives the wire to "stop". It keeps it there until free space climbs above a higher threshold, and then drives it to "go". The wire only moves on those two crossings. The two thresholds form a hysteresis band, so the link does not toggle on every flit.

The sending end sees the wire after a fixed link delay. It injects a flit only when it has one to send and the delayed wire says "go". Injected flits reach the receiver after the same fixed delay. A consumer frees slots in the receive buffer with a one-cycle strobe. The flit payload is outside the block; only the valid bits and counts are modelled.

The low threshold must cover every flit that can still arrive after it is crossed. That is the flits already on the wire plus those sent before the sender sees "stop". The parameters are checked at elaboration so this always holds. An overflow flag is kept for verification.

Top module: `onoff_link`

## Requirements
- R1: While reset is asserted and after it is released with idle inputs, the buffer is empty (free_o equals DEPTH), onoff_o is 1, sender_on_o is 1, rx_valid_o is 0 and overflow_o is 0.
- R2: A flit injected in a cycle (src_send_o high) shows as rx_valid_o high exactly LINK_DLY cycles later. No other rx_valid_o pulses appear.
- R3: free_o drops by one the cycle after an arrival and rises by one the cycle after a drain_i strobe while the buffer holds a flit. An arrival and a drain in the same cycle leave it unchanged. A drain_i strobe on an empty buffer is ignored.
- R4: onoff_o (1 = go, 0 = stop) falls to 0 in the cycle after free_o is below OFF_THR while it was 1.
- R5: onoff_o rises to 1 in the cycle after free_o is above ON_THR while it was 0. While free_o lies within OFF_THR..ON_THR, it keeps its value.
- R6: sender_on_o equals the value onoff_o had LINK_DLY cycles earlier.
- R7: src_send_o is high exactly when src_valid_i is high and sender_on_o is high.
- R8: With legal parameters (OFF_THR >= 2*LINK_DLY+2, OFF_THR < ON_THR < DEPTH), a sender that sends without pause never overflows the buffer. overflow_o is sticky: it goes to 1 on an arrival into a full buffer without a drain, and it stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_valid_i | input | 1 | Sender has a flit ready to inject |
| src_send_o | output | 1 | Flit injected onto the link this cycle |
| rx_valid_o | output | 1 | Flit arriving at the receive buffer this cycle |
| drain_i | input | 1 | Consumer frees one receive slot |
| free_o | output | $clog2(DEPTH+1) | Free receive slots |
| onoff_o | output | 1 | Control wire at the receiver, 1 = go, 0 = stop |
| sender_on_o | output | 1 | Control wire as seen by the sender after the link delay |
| overflow_o | output | 1 | Sticky receive overflow flag |

## Verification
A single flit on an idle link shows the forward latency on its own. A sender that never pauses, with no drain, fills the buffer to the last slot: this tells a correctly sized stop threshold from an off-by-one in either delay path. A slow drain then walks free space through the hysteresis band and just past the upper threshold, which tells true hysteresis apart from a single-threshold design. Long pseudo-random mixes of send and drain, plus drain strobes on an empty buffer, cover simultaneous arrival and release and the ignored-drain case.

// File: rtl/onoff_pkg.sv
package onoff_pkg;
  typedef enum logic {
    LINK_STOP = 1'b0,
    LINK_GO   = 1'b1
  } link_state_e;
endpackage

// File: rtl/onoff_rst_sync.sv
module onoff_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/onoff_delay_line.sv
module onoff_delay_line #(
  parameter int unsigned       W       = 1,
  parameter int unsigned       DLY     = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [DLY];
  logic [W-1:0] stage_d [DLY];

  for (genvar k = 0; k < DLY; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign stage_d[k] = d_i;
    end else begin : g_next
      assign stage_d[k] = stage_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) stage_q[k] <= RST_VAL;
      else         stage_q[k] <= stage_d[k];
    end
  end

  assign q_o = stage_q[DLY-1];
endmodule

// File: rtl/onoff_rx_buffer.sv
module onoff_rx_buffer #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          arrive_i,
  input  logic          drain_i,
  output logic [CW-1:0] free_o,
  output logic          overflow_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] occ_q, occ_d;
  logic          ovf_q, ovf_d;
  logic          pop;
  logic          full;
  logic          occ_en;

  assign full = (occ_q == FULL_CNT);
  assign pop  = drain_i && (occ_q != '0);

  always_comb begin
    occ_d  = occ_q;
    ovf_d  = ovf_q;
    occ_en = 1'b0;
    unique case ({arrive_i, pop})
      2'b10: begin
        if (full) begin
          ovf_d = 1'b1;
        end else begin
          occ_d  = occ_q + 1'b1;
          occ_en = 1'b1;
        end
      end
      2'b01: begin
        occ_d  = occ_q - 1'b1;
        occ_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (occ_en) occ_q <= occ_d;
      ovf_q <= ovf_d;
    end
  end

  assign free_o     = FULL_CNT - occ_q;
  assign overflow_o = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    !(arrive_i && !pop && full)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R8
  AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (occ_q == $past(occ_q) || occ_q == $past(occ_q) + 1'b1 ||
              occ_q == $past(occ_q) - 1'b1)); // R3
endmodule

// File: rtl/onoff_hyst_ctrl.sv
module onoff_hyst_ctrl
  import onoff_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned OFF_THR = 6,
  parameter int unsigned ON_THR  = 10,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [CW-1:0] free_i,
  output logic          go_o
);
  localparam logic [CW-1:0] LOW_LIM  = CW'(OFF_THR);
  localparam logic [CW-1:0] HIGH_LIM = CW'(ON_THR);

  link_state_e state_q, state_d;
  logic        below_low, above_high;

  assign below_low  = (free_i < LOW_LIM);
  assign above_high = (free_i > HIGH_LIM);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LINK_GO:   if (below_low)  state_d = LINK_STOP;
      LINK_STOP: if (above_high) state_d = LINK_GO;
      default:   state_d = LINK_GO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= LINK_GO;
    else         state_q <= state_d;
  end

  assign go_o = (state_q == LINK_GO);

  AST_STOP_BELOW_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(go_o) |-> ($past(free_i) < LOW_LIM)); // R4
  AST_GO_ABOVE_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(go_o) |-> ($past(free_i) > HIGH_LIM)); // R5
  AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_ni)
    (free_i >= LOW_LIM && free_i <= HIGH_LIM) |=> $stable(go_o)); // R5
endmodule

// File: rtl/onoff_link.sv
module onoff_link #(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned OFF_THR  = 6,
  parameter int unsigned ON_THR   = 10,
  parameter int unsigned LINK_DLY = 2,
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          src_valid_i,
  output logic          src_send_o,
  output logic          rx_valid_o,
  input  logic          drain_i,
  output logic [CW-1:0] free_o,
  output logic          onoff_o,
  output logic          sender_on_o,
  output logic          overflow_o
);
  if (LINK_DLY < 1) begin : g_bad_dly
    $error("link delay must be at least one cycle");
  end
  if (ON_THR <= OFF_THR) begin : g_bad_band
    $error("upper threshold must exceed lower threshold");
  end
  if (ON_THR >= DEPTH) begin : g_bad_high
    $error("upper threshold must be below buffer depth");
  end
  if (OFF_THR < 2 * LINK_DLY + 2) begin : g_bad_low
    $error("lower threshold cannot absorb in-flight flits");
  end

  logic rst_sync_n;
  logic go_rx;
  logic go_tx;
  logic send;
  logic arrive;

  onoff_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  assign send = src_valid_i & go_tx;

  onoff_delay_line #(.W(1), .DLY(LINK_DLY), .RST_VAL(1'b0)) i_fwd_line (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .d_i    (send),
    .q_o    (arrive)
  );

  onoff_rx_buffer #(.DEPTH(DEPTH)) i_rx_buf (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .arrive_i   (arrive),
    .drain_i    (drain_i),
    .free_o     (free_o),
    .overflow_o (overflow_o)
  );

  onoff_hyst_ctrl #(.DEPTH(DEPTH), .OFF_THR(OFF_THR), .ON_THR(ON_THR)) i_ctrl (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .free_i (free_o),
    .go_o   (go_rx)
  );

  onoff_delay_line #(.W(1), .DLY(LINK_DLY), .RST_VAL(1'b1)) i_back_line (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .d_i    (go_rx),
    .q_o    (go_tx)
  );

  assign src_send_o  = send;
  assign rx_valid_o  = arrive;
  assign onoff_o     = go_rx;
  assign sender_on_o = go_tx;
endmodule

// File: tb/test_onoff_link.sv
`timescale 1ns/1ps
module test_onoff_link;
  localparam int DEPTH = 16;
  localparam int OFFT  = 6;
  localparam int ONT   = 10;
  localparam int LDLY  = 2;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          src_valid_i;
  logic          src_send_o;
  logic          rx_valid_o;
  logic          drain_i;
  logic [CW-1:0] free_o;
  logic          onoff_o;
  logic          sender_on_o;
  logic          overflow_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  int  m_occ;
  bit  m_ctl;
  bit  m_ovf;
  bit  fq[$];
  bit  cq[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  onoff_link #(.DEPTH(DEPTH), .OFF_THR(OFFT), .ON_THR(ONT), .LINK_DLY(LDLY)) i_onoff_link (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .src_valid_i (src_valid_i),
    .src_send_o  (src_send_o),
    .rx_valid_o  (rx_valid_o),
    .drain_i     (drain_i),
    .free_o      (free_o),
    .onoff_o     (onoff_o),
    .sender_on_o (sender_on_o),
    .overflow_o  (overflow_o)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic model_init();
    m_occ = 0; m_ctl = 1'b1; m_ovf = 1'b0;
    fq.delete(); cq.delete();
    for (int k = 0; k < LDLY; k++) begin
      fq.push_back(1'b0);
      cq.push_back(1'b1);
    end
  endtask

  task automatic model_step(input bit v, input bit d);
    bit snd, arr, pop, ctl_pre;
    int free_pre;
    snd      = v & cq[0];
    arr      = fq[0];
    pop      = d && (m_occ > 0);
    free_pre = DEPTH - m_occ;
    ctl_pre  = m_ctl;
    if (m_ctl && free_pre < OFFT)      m_ctl = 1'b0;
    else if (!m_ctl && free_pre > ONT) m_ctl = 1'b1;
    void'(cq.pop_front()); cq.push_back(ctl_pre);
    void'(fq.pop_front()); fq.push_back(snd);
    if (arr && !pop) begin
      if (m_occ == DEPTH) m_ovf = 1'b1;
      else                m_occ++;
    end else if (!arr && pop) begin
      m_occ--;
    end
  endtask

  task automatic cycle(input bit v, input bit d);
    @(negedge clk);
    chk("R2 rx_valid",    int'(rx_valid_o),  int'(fq[0]));
    chk("R3 free count",  int'(free_o),      DEPTH - m_occ);
    chk("R4 R5 onoff",    int'(onoff_o),     int'(m_ctl));
    chk("R6 sender_on",   int'(sender_on_o), int'(cq[0]));
    chk("R8 overflow",    int'(overflow_o),  int'(m_ovf));
    src_valid_i = v;
    drain_i     = d;
    #1;
    chk("R7 send gating", int'(src_send_o),  int'(v & cq[0]));
    @(posedge clk);
    model_step(v, d);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_ni = 1'b0; src_valid_i = 1'b0; drain_i = 1'b0;
    model_init();
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1 reset free",      int'(free_o),      DEPTH);
    chk("R1 reset onoff",     int'(onoff_o),     1);
    chk("R1 reset sender_on", int'(sender_on_o), 1);
    chk("R1 reset rx_valid",  int'(rx_valid_o),  0);
    chk("R1 reset overflow",  int'(overflow_o),  0);
    rst_ni = 1'b1;
    repeat (5) cycle(1'b0, 1'b0);
    #1 chk("R1 idle free after release", int'(free_o), DEPTH);

    // R2: lone flit latency
    cycle(1'b1, 1'b0);
    repeat (4) cycle(1'b0, 1'b0);
    #1 chk("R2 R3 one flit landed", int'(free_o), DEPTH - 1);

    // R4 R8: constant sending with no drain fills exactly to full
    repeat (30) cycle(1'b1, 1'b0);
    #1;
    chk("R4 stopped when full",  int'(onoff_o),    0);
    chk("R8 filled to last slot", int'(free_o),    0);
    chk("R8 no overflow at fill", int'(overflow_o), 0);

    // R5: draining inside the band keeps stop
    repeat (8) cycle(1'b1, 1'b1);
    #1;
    chk("R5 free in band",     int'(free_o),  8);
    chk("R5 still stopped",    int'(onoff_o), 0);
    repeat (3) cycle(1'b1, 1'b1);
    #1 chk("R5 free just above band", int'(free_o), ONT + 1);
    chk("R5 not yet go", int'(onoff_o), 0);
    cycle(1'b1, 1'b0);
    #1 chk("R5 go after upper crossing", int'(onoff_o), 1);

    // mixed traffic
    for (int n = 0; n < 800; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[0] | lfsr[3], lfsr[5] & (n[6] | lfsr[7]));
    end

    // R3: drain strobes on an empty buffer are ignored
    repeat (40) cycle(1'b0, 1'b1);
    repeat (3) cycle(1'b0, 1'b1);
    #1;
    chk("R3 drain on empty ignored", int'(free_o),  DEPTH);
    chk("R5 go after full drain",    int'(onoff_o), 1);
    chk("R8 no overflow overall",    int'(overflow_o), 0);

    done = 1;
    finish_run();
  end
endmodule